// File: doc/BRIEF.md
# Pixel Hit Latency Buffer with Trigger Coincidence

This block is the digital back end of one channel of a hybrid pixel readout. A hit from the discriminator, or from an injected test pulse, is held for a fixed trigger latency. The channel does not shift the hit through a chain of stages. It records the current code of a shared, cyclic, Gray-coded time-stamp bus. The wait is over when the bus comes back to that code, which happens exactly one bus period later. At that edge the channel samples the trigger strobe. On a match it copies the recorded stamp into a four-entry local event buffer.

Each channel has two delay units, so a second hit can be held while the first is still waiting. Shared address buses, both Gray-coded, select the buffer slot that is written and the slot that is read. A small counter generator included in the block drives these buses and the time-stamp bus. It advances the write bus once per stored event and the read bus once per removed event. Downstream readout logic drains the buffer one entry per read request. Two sticky flags report events that had to be dropped.

Top module: `pxd_top`

## Requirements
- R1: The time-stamp bus `stampBus` steps once per clock through a cycle of LATENCY codes. After reset the step index i is 0. The code is b ^ (b >> 1), where b = i + (2^STAMP_W − LATENCY)/2. Successive codes, including the wrap from the last code back to the first, differ in exactly one bit.
- R2: The hit source is `testPulse` when `testEn` is 1 and `discHit` when `testEn` is 0. The unselected source has no effect. The source is sampled on every rising clock edge, and each edge on which it is high is one hit.
- R3: While `maskEn` is 1, no hit is captured. This means no delay unit is loaded, `delayOvf` is never set, and no event can later be stored.
- R4: A hit captured at edge P is stored if and only if `trigStrobe` is 1 at edge P+LATENCY. The stored data is the `stampBus` code present at edge P. A strobe one edge early or one edge late stores nothing.
- R5: Two hits can wait at the same time. A hit that arrives while both delay units are waiting, and neither expires on that edge, is dropped and sets the sticky flag `delayOvf`.
- R6: A delay unit is freed at its expiry edge whether or not the strobe matched. A hit on that same edge reuses the unit without an overflow, and a strobe on that edge still stores the expiring event.
- R7: The buffer holds 4 entries and is read oldest first. `rdValid` and `rdData` show the entry at `rdAddr`. A `rdReq` while `rdValid` is 1 removes that entry.
- R8: A coincidence that finds the slot at `wrAddr` still occupied (all 4 entries unread) is dropped and sets the sticky flag `fifoOvf`. Stored entries are left unchanged. Occupancy is judged before any read on the same edge.
- R9: `wrAddr` and `rdAddr` are 2-bit Gray codes that start at 00. `wrAddr` advances one step (00, 01, 11, 10, 00…) per stored event, and `rdAddr` advances one step per removed entry.
- R10: Reset (active-low `rstN`, asynchronous) empties the buffer, frees both delay units and clears both flags. It also returns all three buses to their first code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| discHit | input | 1 | Discriminator hit |
| testPulse | input | 1 | Injected test hit |
| testEn | input | 1 | Selects test pulse as hit source |
| maskEn | input | 1 | Disables hit capture |
| trigStrobe | input | 1 | Trigger strobe |
| rdReq | input | 1 | Remove the entry shown at the read port |
| stampBus | output | STAMP_W | Gray-coded time stamp |
| wrAddr | output | 2 | Gray-coded buffer write address |
| rdAddr | output | 2 | Gray-coded buffer read address |
| rdValid | output | 1 | Entry at rdAddr is occupied |
| rdData | output | STAMP_W | Stamp stored at rdAddr |
| delayOvf | output | 1 | Sticky: hit dropped, both delay units busy |
| fifoOvf | output | 1 | Sticky: coincidence dropped, buffer full |

## Verification
The bench builds the block with LATENCY = 10 and STAMP_W = 4. A full bus period is therefore ten cycles, and the code offset is 3. This makes it cheap to capture a hit at every one of the ten bus phases, including the phase just before the wrap, and to check each stored stamp against a computed Gray code. With such a short latency, both delay units can be filled and overflowed, and a unit can be reused on its expiry edge, within a few dozen cycles. The five coincidences needed to overflow the buffer also fit in that span. Every bus transition is checked for a single-bit change throughout the run.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic [1:0] load;       // capture stamp into delay unit i
    logic       writeSel;   // which unit's stamp is written to the buffer
    logic       fifoWrite;  // store an accepted event
    logic       fifoRead;   // remove the entry at the read address
  } pxdCtl_t;

  // Gray to binary by prefix xor.
  function automatic logic [31:0] grayToBin(logic [31:0] g);
    logic [31:0] r;
    r = g;
    for (int s = 1; s < 32; s = s * 2) r = r ^ (r >> s);
    return r;
  endfunction

endpackage

// File: rtl/pxd_gray_gen.sv
module pxd_gray_gen #(
  parameter int MOD = 160,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  output logic [W-1:0] code
);
  // Centred window of the reflected code: the first and last codes differ in one bit.
  localparam int OFS = ((1 << W) - MOD) / 2;
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] BASE = W'(OFS);

  logic [W-1:0] idx;
  logic [W-1:0] bin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        idx <= '0;
    else if (advance) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assign bin  = idx + BASE;
  assign code = bin ^ (bin >> 1);

  // R1 / R9: every step, wrap included, toggles at most one bit
  p_one_bit_step_r1_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(code ^ $past(code)) <= 1);

endmodule

// File: rtl/pxd_ctrl.sv
module pxd_ctrl
  import pxd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       discHit,
  input  logic       testPulse,
  input  logic       testEn,
  input  logic       maskEn,
  input  logic       trigStrobe,
  input  logic       rdReq,
  input  logic [1:0] match,
  input  logic       slotFree,
  input  logic       slotValid,
  output pxdCtl_t    ctl,
  output logic       delayOvf,
  output logic       fifoOvf
);
  logic       hitIn;
  logic [1:0] busy;
  logic [1:0] expire;
  logic [1:0] avail;
  logic       accept;

  assign hitIn  = !maskEn && (testEn ? testPulse : discHit);
  assign expire = busy & match;
  assign avail  = ~busy | expire;
  assign accept = (|expire) && trigStrobe;

  always_comb begin
    ctl = '0;
    if (hitIn) begin
      if (avail[0])      ctl.load = 2'b01;
      else if (avail[1]) ctl.load = 2'b10;
    end
    ctl.writeSel  = expire[1];
    ctl.fifoWrite = accept && slotFree;
    ctl.fifoRead  = rdReq && slotValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= '0;
      delayOvf <= 1'b0;
      fifoOvf  <= 1'b0;
    end else begin
      busy <= (busy & ~expire) | ctl.load;
      if (hitIn && avail == 2'b00) delayOvf <= 1'b1;
      if (accept && !slotFree)     fifoOvf  <= 1'b1;
    end
  end

  // R5: at most one unit loads per edge
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.load));

  // R5: a hit with both units held and none expiring raises the flag
  p_delay_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && busy == 2'b11 && expire == 2'b00) |=> delayOvf);

  // R6: an expiring unit that is not reloaded is free on the next edge
  p_expire_frees_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expire[0] && !ctl.load[0]) |=> !busy[0]);

  // R5: flags are sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    delayOvf |=> delayOvf);

endmodule

// File: rtl/pxd_datapath.sv
module pxd_datapath
  import pxd_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  pxdCtl_t       ctl,
  input  logic [W-1:0]  stampBus,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [1:0]    match,
  output logic          slotFree,
  output logic          slotValid,
  output logic [W-1:0]  rdData
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]     latched [2];
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] occ;
  logic [AW-1:0]    wrIdx;
  logic [AW-1:0]    rdIdx;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            latched[u] <= '0;
      else if (ctl.load[u]) latched[u] <= stampBus;
    end
    assign match[u] = (latched[u] == stampBus);
  end

  assign wrIdx     = AW'(grayToBin(32'(wrAddr)));
  assign rdIdx     = AW'(grayToBin(32'(rdAddr)));
  assign slotFree  = !occ[wrIdx];
  assign slotValid = occ[rdIdx];
  assign rdData    = mem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else begin
      if (ctl.fifoWrite) occ[wrIdx] <= 1'b1;
      if (ctl.fifoRead)  occ[rdIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fifoWrite) mem[wrIdx] <= latched[ctl.writeSel];
  end

  // R8: the control never writes into an occupied slot
  p_write_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fifoWrite |-> slotFree);

  // R8: a full buffer without a read keeps its occupancy
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '1 && !ctl.fifoRead) |=> occ == '1);

  // R7: a removal only targets an occupied slot
  p_read_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fifoRead |-> slotValid);

endmodule

// File: rtl/pxd_top.sv
module pxd_top
  import pxd_pkg::*;
#(
  parameter int LATENCY = 160,
  parameter int STAMP_W = 8,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               discHit,
  input  logic               testPulse,
  input  logic               testEn,
  input  logic               maskEn,
  input  logic               trigStrobe,
  input  logic               rdReq,
  output logic [STAMP_W-1:0] stampBus,
  output logic [1:0]         wrAddr,
  output logic [1:0]         rdAddr,
  output logic               rdValid,
  output logic [STAMP_W-1:0] rdData,
  output logic               delayOvf,
  output logic               fifoOvf
);
  localparam int AW = $clog2(DEPTH);

  pxdCtl_t    ctl;
  logic [1:0] match;
  logic       slotFree;

  pxd_gray_gen #(.MOD(LATENCY), .W(STAMP_W)) u_stamp (
    .clk(clk), .rstN(rstN), .advance(1'b1), .code(stampBus));

  pxd_gray_gen #(.MOD(DEPTH), .W(AW)) u_wrPtr (
    .clk(clk), .rstN(rstN), .advance(ctl.fifoWrite), .code(wrAddr));

  pxd_gray_gen #(.MOD(DEPTH), .W(AW)) u_rdPtr (
    .clk(clk), .rstN(rstN), .advance(ctl.fifoRead), .code(rdAddr));

  pxd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .discHit(discHit), .testPulse(testPulse),
    .testEn(testEn), .maskEn(maskEn), .trigStrobe(trigStrobe), .rdReq(rdReq),
    .match(match), .slotFree(slotFree), .slotValid(rdValid), .ctl(ctl),
    .delayOvf(delayOvf), .fifoOvf(fifoOvf));

  pxd_datapath #(.W(STAMP_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stampBus(stampBus),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .match(match), .slotFree(slotFree),
    .slotValid(rdValid), .rdData(rdData));

endmodule

// File: tb/sim_pxd_top.sv
module sim_pxd_top;
  localparam int N   = 10;
  localparam int W   = 4;
  localparam int OFS = ((1 << W) - N) / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic discHit = 1'b0, testPulse = 1'b0, testEn = 1'b0, maskEn = 1'b0;
  logic trigStrobe = 1'b0, rdReq = 1'b0;
  logic [W-1:0] stampBus, rdData;
  logic [1:0]   wrAddr, rdAddr;
  logic         rdValid, delayOvf, fifoOvf;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  int wrCount = 0;
  bit done = 1'b0;
  bit prevOk = 1'b0;
  logic [W-1:0] prevStamp;
  logic [1:0]   prevWr, prevRd;

  always #5 clk = ~clk;

  pxd_top #(.LATENCY(N), .STAMP_W(W), .DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .discHit(discHit), .testPulse(testPulse),
    .testEn(testEn), .maskEn(maskEn), .trigStrobe(trigStrobe), .rdReq(rdReq),
    .stampBus(stampBus), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .delayOvf(delayOvf), .fifoOvf(fifoOvf));

  function automatic logic [W-1:0] gcode(int i);
    int b;
    b = (i % N) + OFS;
    return W'(b ^ (b >> 1));
  endfunction

  function automatic logic [1:0] acode(int c);
    int b;
    b = c % 4;
    return 2'(b ^ (b >> 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    discHit = 0; testPulse = 0; testEn = 0; maskEn = 0; trigStrobe = 0; rdReq = 0;
    wrCount = 0;
    cyc(2);
    rstN = 1'b1;
  endtask

  task automatic readExpect(input logic [W-1:0] exp, input string req);
    chk(rdValid === 1'b1, req, rdValid, 1);
    chk(rdData === exp, req, rdData, exp);
    rdReq = 1'b1; cyc(1); rdReq = 1'b0;
  endtask

  // phase tracks the bus index the design should present (R1)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 0;
    else       phase <= (phase + 1) % N;
  end

  // R1 / R9: continuous bus monitor
  always @(negedge clk) begin
    if (!rstN) prevOk <= 1'b0;
    else begin
      chk(stampBus === gcode(phase), "R1 stamp code", stampBus, gcode(phase));
      if (prevOk) begin
        chk($countones(stampBus ^ prevStamp) == 1, "R1 one-bit step",
            $countones(stampBus ^ prevStamp), 1);
        chk($countones(wrAddr ^ prevWr) <= 1 && $countones(rdAddr ^ prevRd) <= 1,
            "R9 address one-bit step", $countones(wrAddr ^ prevWr), 1);
      end
      prevStamp <= stampBus; prevWr <= wrAddr; prevRd <= rdAddr;
      prevOk <= 1'b1;
    end
  end

  initial begin
    int p;
    logic [W-1:0] st [5];

    // R10: reset state
    doReset();
    chk(rdValid === 1'b0, "R10 rdValid", rdValid, 0);
    chk(delayOvf === 1'b0 && fifoOvf === 1'b0, "R10 flags", {delayOvf, fifoOvf}, 0);
    chk(wrAddr === 2'b00 && rdAddr === 2'b00, "R10 addresses", {wrAddr, rdAddr}, 0);
    chk(stampBus === gcode(0), "R10 stamp", stampBus, gcode(0));

    // R4: hit at every bus phase, strobe exactly at expiry
    for (int off = 0; off < N; off++) begin
      while (phase != off) cyc(1);
      discHit = 1; cyc(1); discHit = 0;
      cyc(N - 1);
      trigStrobe = 1; cyc(1); trigStrobe = 0;
      wrCount++;
      chk(wrAddr === acode(wrCount), "R9 wrAddr step", wrAddr, acode(wrCount));
      readExpect(gcode(off), "R4 phase sweep");
      chk(rdValid === 1'b0, "R7 empty after read", rdValid, 0);
      chk(rdAddr === acode(wrCount), "R9 rdAddr step", rdAddr, acode(wrCount));
    end

    // R4: strobe one edge early and one edge late stores nothing
    doReset();
    discHit = 1; cyc(1); discHit = 0;
    cyc(N - 2);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    cyc(1);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    chk(rdValid === 1'b0, "R4 off-by-one strobe", rdValid, 0);
    chk(delayOvf === 1'b0, "R6 unit freed without match", delayOvf, 0);

    // R5: two waiting hits, third dropped
    doReset();
    p = phase;
    discHit = 1; cyc(3); discHit = 0;
    chk(delayOvf === 1'b1, "R5 third hit overflow", delayOvf, 1);
    cyc(N - 3);
    trigStrobe = 1; cyc(2); trigStrobe = 0;
    cyc(1);
    readExpect(gcode(p), "R5 first unit");
    readExpect(gcode(p + 1), "R5 second unit");
    chk(rdValid === 1'b0, "R5 dropped hit not stored", rdValid, 0);
    chk(delayOvf === 1'b1, "R5 sticky flag", delayOvf, 1);

    // R6: hit and strobe on the expiry edge of a full pair
    doReset();
    p = phase;
    discHit = 1; cyc(2); discHit = 0;
    cyc(N - 2);
    discHit = 1; trigStrobe = 1; cyc(1); discHit = 0;
    cyc(1); trigStrobe = 0;
    chk(delayOvf === 1'b0, "R6 reuse on expiry", delayOvf, 0);
    cyc(N - 2);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    readExpect(gcode(p), "R6 expiring event stored");
    readExpect(gcode(p + 1), "R6 second event");
    readExpect(gcode(p), "R6 reused unit event");

    // R8: five coincidences into four slots
    doReset();
    for (int k = 0; k < 5; k++) begin
      st[k] = gcode(phase);
      discHit = 1; cyc(1); discHit = 0;
      cyc(N - 1);
      trigStrobe = 1; cyc(1); trigStrobe = 0;
      if (k == 3) chk(fifoOvf === 1'b0, "R8 no flag at four", fifoOvf, 0);
    end
    chk(fifoOvf === 1'b1, "R8 overflow flag", fifoOvf, 1);
    chk(wrAddr === 2'b00, "R9 wrAddr wrapped", wrAddr, 0);
    for (int k = 0; k < 4; k++) readExpect(st[k], "R7 oldest first");
    chk(rdValid === 1'b0, "R8 fifth event dropped", rdValid, 0);

    // R3: masked pixel records nothing
    doReset();
    maskEn = 1;
    discHit = 1; cyc(3); discHit = 0;
    trigStrobe = 1; cyc(N + 3); trigStrobe = 0;
    chk(rdValid === 1'b0, "R3 masked no event", rdValid, 0);
    chk(delayOvf === 1'b0, "R3 masked no capture", delayOvf, 0);
    maskEn = 0;

    // R2: source selection
    doReset();
    testEn = 1;
    discHit = 1; cyc(1); discHit = 0;
    cyc(N - 1);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    chk(rdValid === 1'b0, "R2 discriminator ignored in test mode", rdValid, 0);
    p = phase;
    testPulse = 1; cyc(1); testPulse = 0;
    cyc(N - 1);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    readExpect(gcode(p), "R2 test pulse accepted");
    testEn = 0;
    testPulse = 1; cyc(1); testPulse = 0;
    cyc(N - 1);
    trigStrobe = 1; cyc(1); trigStrobe = 0;
    chk(rdValid === 1'b0, "R2 test pulse ignored", rdValid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule